// File: doc/BRIEF.md
# Biased Random Instruction Word Generator

This block is a synthesizable stimulus source for a 32-bit RISC-V core under test. Each accepted request produces one instruction word. The word starts as 32 pseudo-random bits. Most of the time the low seven bits are then overwritten with a legal base opcode. Less often, one field mutation is applied on top. A mutation can pin the immediate to an edge value, zero or alias register specifiers, or point the CSR selector at a machine-mode CSR that exists. The mix keeps most words decodable while still reaching illegal encodings now and then.

All randomness comes from one 32-bit Galois LFSR. A seed input can load it. For each request the block takes three 32-bit draws, each 32 shift steps apart. The first draw is the raw word. Three 10-bit slices of the second draw decide, by threshold compares, whether to inject an opcode, whether to mutate and whether a new multi-instruction sequence starts. The third draw supplies the table selectors. Sequence templates themselves are not built. A flag marks the word at which a new sequence would begin, and the following words of that sequence are counted off.

Top module: `rv_stim_gen`

## Requirements
- R1: After reset, `valid`, `seq_start` and `insn` are all zero and the LFSR holds the reset seed 32'h0000_0001.
- R2: The LFSR shifts right. When the bit shifted out is 1, the new value is XORed with 32'h8020_0003. For each accepted request, A is the state 32 steps on, B is 32 steps after A and C is 32 steps after B. The LFSR then holds C. The raw word is A.
- R3: If B[9:0] < 1003, insn[6:0] is replaced by entry C[3:0] mod 11 of this ordered list: 0110111, 0010111, 1101111, 1100111, 1100011, 0000011, 0100011, 0010011, 0110011, 0001111, 1110011. All other bits keep their raw values.
- R4: If B[19:10] < 205, one mutation is applied after the opcode step. The kind is C[7:4] mod 7: 0 immediate, 1 rd[11:7]=0, 2 rd=rs1[19:15], 3 rd=rs2[24:20], 4 rd=rs1 and rs2=rs1, 5 rs1=rs2, 6 CSR. Otherwise no field changes.
- R5: An immediate mutation writes insn[31:20] with entry C[11:8] mod 5 of: 12'h000, 12'h001, 12'hFFF, 12'h7FF, 12'h800.
- R6: A CSR mutation writes insn[31:20] with entry C[15:12] mod 5 of: 12'h300, 12'h305, 12'h341, 12'h342, 12'h340.
- R7: When no sequence is active and B[29:20] < 10, `seq_start` is 1 for that word, and the next SEQ_LEN-1 (default 3) words continue the sequence with `seq_start` 0. Otherwise `seq_start` is 0.
- R8: The cycle after an accepted request, `valid` is 1 for exactly one cycle and `insn`/`seq_start` show the new word. With no accepted request, `valid` is 0 and `insn`/`seq_start` hold.
- R9: `seed_load` takes priority over `req`. It loads the LFSR with `seed_value`, or with 32'h1D87_2B41 when `seed_value` is zero. It ends any active sequence, produces no word, and leaves `insn` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| seed_load | input | 1 | Load the LFSR from `seed_value` this cycle |
| seed_value | input | 32 | Seed to load; zero is substituted |
| req | input | 1 | Request one instruction word |
| valid | output | 1 | One-cycle pulse: a new word is on `insn` |
| insn | output | 32 | Generated instruction word, held between requests |
| seq_start | output | 1 | The current word would begin a new instruction sequence |

## Verification
The bench builds the block with its default parameters: 10-bit decision slices, thresholds 1003, 205 and 10, and a sequence length of 4. With a short sequence and the 1% start rate, a few thousand requests produce a good number of sequence starts, each with its continuation window. All seven mutation kinds, the rare raw-opcode path and the CSR and immediate tables are also reached. Reseeds are mixed in at random, and some of them are zero. These reseeds cut through active sequences, and one of them lands in the same cycle as a request.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  localparam int unsigned WORD_W = 32;

  typedef enum logic [2:0] {
    MUT_IMM     = 3'd0,
    MUT_RD_ZERO = 3'd1,
    MUT_RD_RS1  = 3'd2,
    MUT_RD_RS2  = 3'd3,
    MUT_RD_BOTH = 3'd4,
    MUT_RS1_RS2 = 3'd5,
    MUT_CSR     = 3'd6
  } mut_kind_e;

  // legal base opcodes, picked by a 4-bit selector reduced mod 11
  function automatic logic [6:0] opcode_at(input logic [3:0] raw);
    logic [3:0] idx;
    idx = raw % 4'd11;
    case (idx)
      4'd0:    return 7'b0110111;
      4'd1:    return 7'b0010111;
      4'd2:    return 7'b1101111;
      4'd3:    return 7'b1100111;
      4'd4:    return 7'b1100011;
      4'd5:    return 7'b0000011;
      4'd6:    return 7'b0100011;
      4'd7:    return 7'b0010011;
      4'd8:    return 7'b0110011;
      4'd9:    return 7'b0001111;
      default: return 7'b1110011;
    endcase
  endfunction

  function automatic mut_kind_e mut_kind(input logic [3:0] raw);
    logic [3:0] idx;
    idx = raw % 4'd7;
    case (idx)
      4'd0:    return MUT_IMM;
      4'd1:    return MUT_RD_ZERO;
      4'd2:    return MUT_RD_RS1;
      4'd3:    return MUT_RD_RS2;
      4'd4:    return MUT_RD_BOTH;
      4'd5:    return MUT_RS1_RS2;
      default: return MUT_CSR;
    endcase
  endfunction

  function automatic logic [11:0] special_imm(input logic [3:0] raw);
    logic [3:0] idx;
    idx = raw % 4'd5;
    case (idx)
      4'd0:    return 12'h000;
      4'd1:    return 12'h001;
      4'd2:    return 12'hFFF;
      4'd3:    return 12'h7FF;
      default: return 12'h800;
    endcase
  endfunction

  function automatic logic [11:0] csr_addr(input logic [3:0] raw);
    logic [3:0] idx;
    idx = raw % 4'd5;
    case (idx)
      4'd0:    return 12'h300;
      4'd1:    return 12'h305;
      4'd2:    return 12'h341;
      4'd3:    return 12'h342;
      default: return 12'h340;
    endcase
  endfunction

endpackage

// File: rtl/rsg_draws.sv
// Unrolled Galois LFSR: DRAWS words, each STEPS shifts after the previous.
module rsg_draws #(
  parameter int unsigned       WIDTH = 32,
  parameter logic [WIDTH-1:0]  TAPS  = 32'h8020_0003,
  parameter int unsigned       STEPS = 32,
  parameter int unsigned       DRAWS = 3
) (
  input  logic [WIDTH-1:0]             state_i,
  output logic [DRAWS-1:0][WIDTH-1:0]  draw_o
);

  localparam int unsigned CHAIN = DRAWS * STEPS;

  logic [WIDTH-1:0] chain [CHAIN+1];

  assign chain[0] = state_i;

  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_step
      assign chain[i+1] = chain[i][0] ? ((chain[i] >> 1) ^ TAPS)
                                      : (chain[i] >> 1);
    end
    for (genvar d = 0; d < DRAWS; d++) begin : g_tap
      assign draw_o[d] = chain[(d+1)*STEPS];
    end
  endgenerate

endmodule

// File: rtl/rsg_decide.sv
// One probability decision: slice below threshold.
module rsg_decide #(
  parameter int unsigned SLICE_W = 10,
  parameter int unsigned THRESH  = 1003
) (
  input  logic [SLICE_W-1:0] slice_i,
  output logic               hit_o
);

  assign hit_o = (32'(slice_i) < THRESH);

endmodule

// File: rtl/rsg_inject.sv
module rsg_inject
  import rsg_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              en_i,
  input  logic [3:0]        sel_i,
  output logic [WORD_W-1:0] word_o
);

  always_comb begin
    word_o = word_i;
    if (en_i) begin
      word_o[6:0] = opcode_at(sel_i);
    end
  end

endmodule

// File: rtl/rsg_mutate.sv
module rsg_mutate
  import rsg_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  input  logic              en_i,
  input  logic [3:0]        kind_sel_i,
  input  logic [3:0]        imm_sel_i,
  input  logic [3:0]        csr_sel_i,
  output logic [WORD_W-1:0] word_o
);

  logic [4:0] rs1_f;
  logic [4:0] rs2_f;

  assign rs1_f = word_i[19:15];
  assign rs2_f = word_i[24:20];

  always_comb begin
    word_o = word_i;
    if (en_i) begin
      case (mut_kind(kind_sel_i))
        MUT_IMM:     word_o[31:20] = special_imm(imm_sel_i);
        MUT_RD_ZERO: word_o[11:7]  = 5'd0;
        MUT_RD_RS1:  word_o[11:7]  = rs1_f;
        MUT_RD_RS2:  word_o[11:7]  = rs2_f;
        MUT_RD_BOTH: begin
          word_o[11:7]  = rs1_f;
          word_o[24:20] = rs1_f;
        end
        MUT_RS1_RS2: word_o[19:15] = rs2_f;
        MUT_CSR:     word_o[31:20] = csr_addr(csr_sel_i);
        default:     word_o = word_i;
      endcase
    end
  end

endmodule

// File: rtl/rv_stim_gen.sv
module rv_stim_gen
  import rsg_pkg::*;
#(
  parameter logic [31:0] LFSR_TAPS     = 32'h8020_0003,
  parameter logic [31:0] RESET_SEED    = 32'h0000_0001,
  parameter logic [31:0] ZERO_SEED_SUB = 32'h1D87_2B41,
  parameter int unsigned STEPS_PER_DRAW = 32,
  parameter int unsigned SLICE_W       = 10,
  parameter int unsigned INJECT_THRESH = 1003,
  parameter int unsigned MUTATE_THRESH = 205,
  parameter int unsigned SEQ_THRESH    = 10,
  parameter int unsigned SEQ_LEN       = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        seed_load,
  input  logic [31:0] seed_value,
  input  logic        req,
  output logic        valid,
  output logic [31:0] insn,
  output logic        seq_start
);

  localparam int unsigned NUM_DRAWS = 3;
  localparam int unsigned NUM_DEC   = 3;
  localparam int unsigned CNT_W     = $clog2(SEQ_LEN + 1);
  localparam logic [CNT_W-1:0] SEQ_TAIL = CNT_W'(SEQ_LEN - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_ok = rst_sync_q[1];

  // state
  logic [WORD_W-1:0] lfsr_q, lfsr_d;
  logic [WORD_W-1:0] insn_q, insn_d;
  logic              seq_q, seq_d;
  logic              valid_q, valid_d;
  logic [CNT_W-1:0]  seq_cnt_q, seq_cnt_d;
  logic              seq_busy;
  logic              accept;
  logic              state_en;

  // random draws
  logic [NUM_DRAWS-1:0][WORD_W-1:0] draws;

  rsg_draws #(
    .WIDTH (WORD_W),
    .TAPS  (LFSR_TAPS),
    .STEPS (STEPS_PER_DRAW),
    .DRAWS (NUM_DRAWS)
  ) u_draws (
    .state_i (lfsr_q),
    .draw_o  (draws)
  );

  // decisions: 0 inject, 1 mutate, 2 sequence start
  logic [NUM_DEC-1:0] hit;

  generate
    for (genvar k = 0; k < NUM_DEC; k++) begin : g_dec
      rsg_decide #(
        .SLICE_W (SLICE_W),
        .THRESH  ((k == 0) ? INJECT_THRESH :
                  (k == 1) ? MUTATE_THRESH : SEQ_THRESH)
      ) u_dec (
        .slice_i (draws[1][k*SLICE_W +: SLICE_W]),
        .hit_o   (hit[k])
      );
    end
  endgenerate

  logic unused_bits;
  assign unused_bits = ^{draws[1][WORD_W-1:NUM_DEC*SLICE_W], draws[2][31:16]};

  // word assembly
  logic [WORD_W-1:0] word_inj;
  logic [WORD_W-1:0] word_mut;

  rsg_inject u_inject (
    .word_i (draws[0]),
    .en_i   (hit[0]),
    .sel_i  (draws[2][3:0]),
    .word_o (word_inj)
  );

  rsg_mutate u_mutate (
    .word_i     (word_inj),
    .en_i       (hit[1]),
    .kind_sel_i (draws[2][7:4]),
    .imm_sel_i  (draws[2][11:8]),
    .csr_sel_i  (draws[2][15:12]),
    .word_o     (word_mut)
  );

  assign accept   = req && !seed_load;
  assign state_en = req || seed_load;
  assign seq_busy = (seq_cnt_q != '0);

  // next state
  always_comb begin
    lfsr_d    = lfsr_q;
    insn_d    = insn_q;
    seq_d     = seq_q;
    seq_cnt_d = seq_cnt_q;
    valid_d   = 1'b0;
    if (seed_load) begin
      lfsr_d    = (seed_value == '0) ? ZERO_SEED_SUB : seed_value;
      seq_cnt_d = '0;
    end else if (req) begin
      lfsr_d  = draws[NUM_DRAWS-1];
      insn_d  = word_mut;
      valid_d = 1'b1;
      if (seq_busy) begin
        seq_cnt_d = seq_cnt_q - 1'b1;
        seq_d     = 1'b0;
      end else if (hit[2]) begin
        seq_cnt_d = SEQ_TAIL;
        seq_d     = 1'b1;
      end else begin
        seq_d     = 1'b0;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      lfsr_q    <= RESET_SEED;
      insn_q    <= '0;
      seq_q     <= 1'b0;
      seq_cnt_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      if (state_en) begin
        lfsr_q    <= lfsr_d;
        seq_cnt_q <= seq_cnt_d;
      end
      if (accept) begin
        insn_q <= insn_d;
        seq_q  <= seq_d;
      end
    end
  end

  assign valid     = valid_q;
  assign insn      = insn_q;
  assign seq_start = seq_q;

endmodule

// File: rtl/rsg_chk.sv
module rsg_chk (
  input logic        clk,
  input logic        rst_ok,
  input logic        req,
  input logic        seed_load,
  input logic        valid,
  input logic [31:0] insn,
  input logic        seq_start,
  input logic [31:0] lfsr_q,
  input logic        seq_busy
);

  // R8
  req_valid_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req && !seed_load) |=> valid);

  // R8
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(req && !seed_load) |=> !valid);

  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(req && !seed_load) |=> ($stable(insn) && $stable(seq_start)));

  // R9
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    lfsr_q != 32'h0);

  // R9
  seed_ends_seq_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    seed_load |=> !seq_busy);

  // R7
  seq_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (req && !seed_load && seq_busy) |=> !seq_start);

  // R7
  seq_opens_window_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(seq_start) |-> seq_busy);

endmodule

bind rv_stim_gen rsg_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .req       (req),
  .seed_load (seed_load),
  .valid     (valid),
  .insn      (insn),
  .seq_start (seq_start),
  .lfsr_q    (lfsr_q),
  .seq_busy  (seq_busy)
);

// File: tb/sim_rv_stim_gen.sv
`timescale 1ns/1ps
module sim_rv_stim_gen;

  localparam logic [31:0] TAPS   = 32'h8020_0003;
  localparam logic [31:0] NZ_SUB = 32'h1D87_2B41;
  localparam int          SEQLEN = 4;

  logic        clk;
  logic        rst_n;
  logic        seed_load;
  logic [31:0] seed_value;
  logic        req;
  logic        valid;
  logic [31:0] insn;
  logic        seq_start;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench model
  logic [31:0] m_lfsr;
  logic [31:0] m_insn;
  logic        m_seq;
  int          m_left;
  string       m_tag;
  int          n_starts = 0;
  int          n_mut    = 0;

  rv_stim_gen u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_load  (seed_load),
    .seed_value (seed_value),
    .req        (req),
    .valid      (valid),
    .insn       (insn),
    .seq_start  (seq_start)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] adv32(input logic [31:0] s);
    logic [31:0] v;
    v = s;
    for (int i = 0; i < 32; i++) begin
      if (v[0]) v = (v >> 1) ^ TAPS;
      else      v = v >> 1;
    end
    return v;
  endfunction

  function automatic logic [6:0] exp_opc(input int i);
    logic [6:0] t [11];
    t = '{7'b0110111, 7'b0010111, 7'b1101111, 7'b1100111, 7'b1100011,
          7'b0000011, 7'b0100011, 7'b0010011, 7'b0110011, 7'b0001111,
          7'b1110011};
    return t[i];
  endfunction

  function automatic logic [11:0] exp_imm(input int i);
    logic [11:0] t [5];
    t = '{12'h000, 12'h001, 12'hFFF, 12'h7FF, 12'h800};
    return t[i];
  endfunction

  function automatic logic [11:0] exp_csr(input int i);
    logic [11:0] t [5];
    t = '{12'h300, 12'h305, 12'h341, 12'h342, 12'h340};
    return t[i];
  endfunction

  task automatic model_req();
    logic [31:0] a, b, c, w;
    int kind;
    a = adv32(m_lfsr);
    b = adv32(a);
    c = adv32(b);
    m_lfsr = c;
    w = a;
    m_tag = "R2";
    if (b[9:0] < 10'd1003) begin
      w[6:0] = exp_opc(int'(c[3:0]) % 11);
      m_tag = "R3";
    end
    if (b[19:10] < 10'd205) begin
      kind = int'(c[7:4]) % 7;
      n_mut++;
      m_tag = "R4";
      case (kind)
        0: begin w[31:20] = exp_imm(int'(c[11:8]) % 5); m_tag = "R5"; end
        1: w[11:7] = 5'd0;
        2: w[11:7] = w[19:15];
        3: w[11:7] = w[24:20];
        4: begin w[11:7] = w[19:15]; w[24:20] = w[19:15]; end
        5: w[19:15] = w[24:20];
        default: begin w[31:20] = exp_csr(int'(c[15:12]) % 5); m_tag = "R6"; end
      endcase
    end
    m_insn = w;
    if (m_left > 0) begin
      m_left--;
      m_seq = 1'b0;
    end else if (b[29:20] < 10'd10) begin
      m_left = SEQLEN - 1;
      m_seq = 1'b1;
      n_starts++;
    end else begin
      m_seq = 1'b0;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_req();
    req = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    model_req();
    chk("R8 valid pulse", {31'd0, valid}, 32'd1);
    chk(m_tag, insn, m_insn);
    chk("R7 seq_start", {31'd0, seq_start}, {31'd0, m_seq});
  endtask

  task automatic do_idle();
    @(posedge clk);
    @(negedge clk);
    chk("R8 idle valid", {31'd0, valid}, 32'd0);
    chk("R8 idle hold", insn, m_insn);
    chk("R8 idle seq hold", {31'd0, seq_start}, {31'd0, m_seq});
  endtask

  task automatic do_seed(input logic [31:0] v, input bit with_req);
    seed_load  = 1'b1;
    seed_value = v;
    req        = with_req;
    @(posedge clk);
    @(negedge clk);
    seed_load = 1'b0;
    req       = 1'b0;
    m_lfsr = (v == 32'd0) ? NZ_SUB : v;
    m_left = 0;
    chk("R9 seed no word", {31'd0, valid}, 32'd0);
    chk("R9 seed insn hold", insn, m_insn);
  endtask

  // watchdog
  initial begin
    #(200000 * 8);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int seed_rs;
    seed_rs    = $urandom(32'h5EED);
    rst_n      = 1'b0;
    seed_load  = 1'b0;
    seed_value = 32'd0;
    req        = 1'b0;
    m_lfsr = 32'h1;
    m_insn = 32'd0;
    m_seq  = 1'b0;
    m_left = 0;
    repeat (3) @(negedge clk);
    // R1 reset state, during reset
    chk("R1 valid in reset", {31'd0, valid}, 32'd0);
    chk("R1 insn in reset", insn, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid after reset", {31'd0, valid}, 32'd0);
    chk("R1 insn after reset", insn, 32'd0);
    chk("R1 seq_start after reset", {31'd0, seq_start}, 32'd0);

    // R1 reset seed drives first words
    for (int i = 0; i < 20; i++) do_req();
    do_idle();

    // R9 zero seed substituted
    do_seed(32'd0, 1'b0);
    for (int i = 0; i < 10; i++) do_req();

    // R9 seed load wins over a simultaneous request
    do_seed(32'hCAFE_F00D, 1'b1);
    do_idle();
    for (int i = 0; i < 10; i++) do_req();

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 2) begin
        if ($urandom % 4 == 0) do_seed(32'd0, 1'b0);
        else                   do_seed($urandom, ($urandom % 2) == 1);
      end else if (r < 80) begin
        do_req();
      end else begin
        do_idle();
      end
    end

    // R7 / R4 coverage sanity: the random mix must reach them
    chk("R7 sequence starts seen", {31'd0, n_starts > 0}, 32'd1);
    chk("R4 mutations seen", {31'd0, n_mut > 0}, 32'd1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule